// File: doc/BRIEF.md
# SDRAM Power-Up Command Sequencer

This block drives the command pins of one or two SDRAM chip selects through the power-up sequence that a memory needs before it can be used. Software, or a small boot controller, writes a command word. The word carries an operation code, a target-bank select and the operands the operation needs. The block drives the matching pin pattern and keeps a busy flag high until the timing rule that follows that command has been met. The caller polls busy and then writes the next step.

The intended order is: raise the clock enable and wait out the power-up time, precharge all banks, run a burst of auto-refresh cycles, load the mode register, then switch to normal operation. Every wait is counted in clock cycles and set by a parameter. A write made while busy is high is dropped, and it sets a sticky error flag that only reset clears. The read and write data path, periodic refresh, self-refresh and power-down are outside this block.

Top module: `sdram_init_seq`

## Requirements
- R1: After reset, `cke_o` is 0, `cs_n_o` is 2'b11, `ras_n_o`, `cas_n_o` and `we_n_o` are 1, `addr_o` and `ba_o` are 0, and `busy_o` and `err_o` are 0.
- R2: The command word holds the operation code in bits 2:0. Bit 4 selects chip select 0 (`cs_n_o[0]`) and bit 3 selects chip select 1 (`cs_n_o[1]`); both may be set. A word with neither bit set has no effect on any output.
- R3: Code 1 (clock enable) sets `cke_o` in the first cycle after the write. It drives no command, and it holds `busy_o` high for exactly PWRUP_CYC cycles.
- R4: Code 2 (precharge all) drives one cycle with the selected chip selects low, RAS_n=0, CAS_n=1, WE_n=0 and `addr_o[10]`=1 (all other address bits 0). `busy_o` stays high for T_RP cycles.
- R5: Code 3 (auto-refresh) issues N = field+1 refresh commands, where the field is bits 8:5 of the word. Each refresh is one cycle with RAS_n=0, CAS_n=0 and WE_n=1, and refreshes start T_RC cycles apart. `busy_o` stays high for N*T_RC cycles.
- R6: Code 4 (load mode register) drives one cycle with RAS_n=CAS_n=WE_n=0, `ba_o`=0, and `addr_o` equal to the word bits starting at bit 9. In that payload, bits 2:0 are the burst length and bits 6:4 are the CAS latency. `busy_o` stays high for T_MRD cycles.
- R7: Codes 0, 5, 6 and 7 drive no command and do not raise `busy_o`.
- R8: A write while `busy_o` is high does not change the command in progress. It sets `err_o`, which stays 1 until reset.
- R9: While `cke_o` is 0, every code except 1 has no effect on any output. Once `cke_o` is set, it stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_we_i | input | 1 | Command write strobe, one cycle per command |
| cmd_word_i | input | 9+ADDR_W | Command word: code, bank selects, refresh count, mode payload |
| busy_o | output | 1 | High while a command or its trailing wait is in progress |
| err_o | output | 1 | Sticky flag: a command was written while busy |
| cke_o | output | 1 | SDRAM clock enable |
| cs_n_o | output | 2 | Chip selects, active low |
| ras_n_o | output | 1 | Row address strobe, active low |
| cas_n_o | output | 1 | Column address strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| addr_o | output | ADDR_W | SDRAM address bus |
| ba_o | output | 2 | SDRAM bank address |

## Verification
Directed words come first. One is a precharge sent before the clock enable, to show that a command is dropped while CKE is low. Others use no bank bit, a single bank, and both banks, to show that each chip select is mapped independently. Refresh counts at both ends of the field show whether the count is off by one and whether refreshes are spaced correctly. A write during a long refresh burst tests both the error flag and that the burst keeps running. Random words then mix every code, bank pattern, refresh count and payload. For each word the bench predicts the pin pattern cycle by cycle, which separates timing errors in the wait counters from encoding errors on the pins.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        OP_NORMAL    = 3'd0,
        OP_CLK_EN    = 3'd1,
        OP_PRECHARGE = 3'd2,
        OP_AUTO_REF  = 3'd3,
        OP_LOAD_MODE = 3'd4,
        OP_SELF_REF  = 3'd5,
        OP_POWER_DN  = 3'd6,
        OP_RSVD      = 3'd7
    } op_e;

    // Field positions inside the command word
    localparam int OP_LSB      = 0;
    localparam int OP_W        = 3;
    localparam int SEL1_BIT    = 3;   // drives chip select 1
    localparam int SEL0_BIT    = 4;   // drives chip select 0
    localparam int NREF_LSB    = 5;
    localparam int NREF_W      = 4;
    localparam int PAYLOAD_LSB = 9;
    localparam int NUM_CS      = 2;
    localparam int AP_BIT      = 10;  // auto-precharge / all-banks address bit

    // {ras_n, cas_n, we_n}
    typedef struct packed {
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pins_t;

    localparam pins_t PINS_NOP = '{ras_n: 1'b1, cas_n: 1'b1, we_n: 1'b1};
    localparam pins_t PINS_PRE = '{ras_n: 1'b0, cas_n: 1'b1, we_n: 1'b0};
    localparam pins_t PINS_REF = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b1};
    localparam pins_t PINS_LMR = '{ras_n: 1'b0, cas_n: 1'b0, we_n: 1'b0};

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic [PAYLOAD_LSB+ADDR_W-1:0] word_i,
    output op_e                           op_o,
    output logic [NUM_CS-1:0]             sel_o,
    output logic [NREF_W-1:0]             nref_o,
    output logic [ADDR_W-1:0]             payload_o,
    output logic                          seq_op_o
);
    always_comb begin
        op_o      = op_e'(word_i[OP_LSB +: OP_W]);
        sel_o     = {word_i[SEL1_BIT], word_i[SEL0_BIT]};
        nref_o    = word_i[NREF_LSB +: NREF_W];
        payload_o = word_i[PAYLOAD_LSB +: ADDR_W];
        unique case (op_o)
            OP_CLK_EN, OP_PRECHARGE, OP_AUTO_REF, OP_LOAD_MODE: seq_op_o = 1'b1;
            default:                                            seq_op_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/sdram_pin_enc.sv
module sdram_pin_enc
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W = 13
) (
    input  logic              issue_i,
    input  op_e               op_i,
    input  logic [NUM_CS-1:0] sel_i,
    input  logic [ADDR_W-1:0] payload_i,
    output logic [NUM_CS-1:0] cs_n_o,
    output pins_t             pins_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [1:0]        ba_o
);
    always_comb begin
        cs_n_o = '1;
        pins_o = PINS_NOP;
        addr_o = '0;
        ba_o   = '0;
        if (issue_i) begin
            cs_n_o = ~sel_i;
            unique case (op_i)
                OP_PRECHARGE: begin
                    pins_o         = PINS_PRE;
                    addr_o[AP_BIT] = 1'b1;
                end
                OP_AUTO_REF:  pins_o = PINS_REF;
                OP_LOAD_MODE: begin
                    pins_o = PINS_LMR;
                    addr_o = payload_i;
                end
                default: begin
                    cs_n_o = '1;
                    pins_o = PINS_NOP;
                end
            endcase
        end
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int ADDR_W    = 13,
    parameter int PWRUP_CYC = 20,
    parameter int T_RP      = 2,
    parameter int T_RC      = 3,
    parameter int T_MRD     = 2
) (
    input  logic                          clk_i,
    input  logic                          rst_ni,
    input  logic                          cmd_we_i,
    input  logic [PAYLOAD_LSB+ADDR_W-1:0] cmd_word_i,
    output logic                          busy_o,
    output logic                          err_o,
    output logic                          cke_o,
    output logic [NUM_CS-1:0]             cs_n_o,
    output logic                          ras_n_o,
    output logic                          cas_n_o,
    output logic                          we_n_o,
    output logic [ADDR_W-1:0]             addr_o,
    output logic [1:0]                    ba_o
);
    localparam int MAX_A   = (PWRUP_CYC > T_RP)  ? PWRUP_CYC : T_RP;
    localparam int MAX_B   = (T_RC > T_MRD)      ? T_RC      : T_MRD;
    localparam int MAX_WT  = (MAX_A > MAX_B)     ? MAX_A     : MAX_B;
    localparam int CNT_W   = (MAX_WT > 1) ? $clog2(MAX_WT) : 1;

    typedef struct packed {
        logic              busy;
        logic [CNT_W-1:0]  cnt;
        logic [NREF_W-1:0] rem;
        logic [NUM_CS-1:0] sel;
        logic              cke;
        logic              err;
        logic [NUM_CS-1:0] cs_n;
        pins_t             pins;
        logic [ADDR_W-1:0] addr;
        logic [1:0]        ba;
    } state_t;

    localparam state_t RESET_STATE = '{
        busy: 1'b0, cnt: '0, rem: '0, sel: '0, cke: 1'b0, err: 1'b0,
        cs_n: '1, pins: PINS_NOP, addr: '0, ba: '0
    };

    state_t state_d, state_q;

    op_e               dec_op;
    logic [NUM_CS-1:0] dec_sel;
    logic [NREF_W-1:0] dec_nref;
    logic [ADDR_W-1:0] dec_payload;
    logic              dec_seq;

    sdram_cmd_decode #(.ADDR_W(ADDR_W)) u_decode (
        .word_i    (cmd_word_i),
        .op_o      (dec_op),
        .sel_o     (dec_sel),
        .nref_o    (dec_nref),
        .payload_o (dec_payload),
        .seq_op_o  (dec_seq)
    );

    logic              issue;
    op_e               iss_op;
    logic [NUM_CS-1:0] iss_sel;
    logic              accept;

    logic [NUM_CS-1:0] enc_cs_n;
    pins_t             enc_pins;
    logic [ADDR_W-1:0] enc_addr;
    logic [1:0]        enc_ba;

    sdram_pin_enc #(.ADDR_W(ADDR_W)) u_enc (
        .issue_i   (issue),
        .op_i      (iss_op),
        .sel_i     (iss_sel),
        .payload_i (dec_payload),
        .cs_n_o    (enc_cs_n),
        .pins_o    (enc_pins),
        .addr_o    (enc_addr),
        .ba_o      (enc_ba)
    );

    always_comb begin
        state_d = state_q;
        issue   = 1'b0;
        iss_op  = dec_op;
        iss_sel = dec_sel;
        accept  = cmd_we_i && !state_q.busy && (dec_sel != '0) && dec_seq
                  && (dec_op == OP_CLK_EN || state_q.cke);

        if (cmd_we_i && state_q.busy) begin
            state_d.err = 1'b1;
        end

        if (state_q.busy) begin
            if (state_q.cnt == '0) begin
                if (state_q.rem != '0) begin
                    issue       = 1'b1;
                    iss_op      = OP_AUTO_REF;
                    iss_sel     = state_q.sel;
                    state_d.rem = state_q.rem - 1'b1;
                    state_d.cnt = CNT_W'(T_RC - 1);
                end else begin
                    state_d.busy = 1'b0;
                end
            end else begin
                state_d.cnt = state_q.cnt - 1'b1;
            end
        end else if (accept) begin
            state_d.busy = 1'b1;
            state_d.sel  = dec_sel;
            state_d.rem  = '0;
            unique case (dec_op)
                OP_CLK_EN: begin
                    state_d.cke = 1'b1;
                    state_d.cnt = CNT_W'(PWRUP_CYC - 1);
                end
                OP_PRECHARGE: begin
                    issue       = 1'b1;
                    state_d.cnt = CNT_W'(T_RP - 1);
                end
                OP_AUTO_REF: begin
                    issue       = 1'b1;
                    state_d.cnt = CNT_W'(T_RC - 1);
                    state_d.rem = dec_nref;
                end
                default: begin
                    issue       = 1'b1;
                    state_d.cnt = CNT_W'(T_MRD - 1);
                end
            endcase
        end

        state_d.cs_n = enc_cs_n;
        state_d.pins = enc_pins;
        state_d.addr = enc_addr;
        state_d.ba   = enc_ba;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= RESET_STATE;
        else         state_q <= state_d;
    end

    assign busy_o  = state_q.busy;
    assign err_o   = state_q.err;
    assign cke_o   = state_q.cke;
    assign cs_n_o  = state_q.cs_n;
    assign ras_n_o = state_q.pins.ras_n;
    assign cas_n_o = state_q.pins.cas_n;
    assign we_n_o  = state_q.pins.we_n;
    assign addr_o  = state_q.addr;
    assign ba_o    = state_q.ba;

    // R9
    cke_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cke_o |=> cke_o);

    // R9
    no_cmd_without_cke_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_n_o != '1) |-> cke_o);

    // R8
    busy_write_err_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cmd_we_i && busy_o) |=> err_o);

    // R8
    err_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        err_o |=> err_o);

    // R3
    busy_from_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(cmd_we_i));

    // R4
    precharge_all_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((cs_n_o != '1) && !ras_n_o && cas_n_o && !we_n_o) |-> addr_o[AP_BIT]);

    // R2
    cmd_needs_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cs_n_o != '1) |-> busy_o);

endmodule

// File: tb/sdram_init_seq_tb.sv
module sdram_init_seq_tb_top;
    import sdram_init_pkg::*;

    localparam int ADDR_W = 13;
    localparam int PWRUP  = 20;
    localparam int TRP    = 2;
    localparam int TRC    = 3;
    localparam int TMRD   = 2;
    localparam int CW     = PAYLOAD_LSB + ADDR_W;
    localparam int VW     = 1 + 2 + 3 + ADDR_W + 2 + 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cmd_we = 1'b0;
    logic [CW-1:0] cmd_word = '0;
    logic          busy, err, cke, ras_n, cas_n, we_n;
    logic [1:0]    cs_n, ba;
    logic [ADDR_W-1:0] addr;

    int checks = 0;
    int fails  = 0;
    logic m_cke = 1'b0;
    logic m_err = 1'b0;
    logic done  = 1'b0;

    always #5 clk = ~clk;

    sdram_init_seq #(.ADDR_W(ADDR_W), .PWRUP_CYC(PWRUP), .T_RP(TRP),
                     .T_RC(TRC), .T_MRD(TMRD)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .cmd_we_i(cmd_we), .cmd_word_i(cmd_word),
        .busy_o(busy), .err_o(err), .cke_o(cke), .cs_n_o(cs_n),
        .ras_n_o(ras_n), .cas_n_o(cas_n), .we_n_o(we_n), .addr_o(addr), .ba_o(ba)
    );

    function automatic logic [CW-1:0] mk(input int op, input logic s0, input logic s1,
                                         input int nref, input logic [ADDR_W-1:0] pl);
        logic [CW-1:0] w;
        w = '0;
        w[2:0] = op[2:0];
        w[4]   = s0;
        w[3]   = s1;
        w[8:5] = nref[3:0];
        w[CW-1:9] = pl;
        return w;
    endfunction

    function automatic logic [VW-1:0] expect_vec(input logic [CW-1:0] w, input logic acc,
                                                 input int i, input int dur,
                                                 input logic kcke, input logic kerr);
        int op;
        logic iss;
        logic [1:0] xcs;
        logic [2:0] xp;
        logic [ADDR_W-1:0] xa;
        op  = int'(w[2:0]);
        iss = acc && i < dur && ((op == 3 && (i % TRC) == 0) || ((op == 2 || op == 4) && i == 0));
        xcs = 2'b11;
        xp  = 3'b111;
        xa  = '0;
        if (iss) begin
            xcs = ~{w[3], w[4]};
            if (op == 2) begin xp = 3'b010; xa[10] = 1'b1; end
            else if (op == 3) xp = 3'b001;
            else begin xp = 3'b000; xa = w[CW-1:9]; end
        end
        return {kcke, xcs, xp, xa, 2'b00, (acc && i < dur), kerr};
    endfunction

    function automatic string tag_of(input logic [CW-1:0] w, input logic kcke, input int intr);
        int op;
        op = int'(w[2:0]);
        if (intr >= 0)                  return "R8";
        if (w[4:3] == 2'b00)            return "R2";
        if (op == 0 || op > 4)          return "R7";
        if (!kcke && op != 1)           return "R9";
        case (op)
            1: return "R3";
            2: return "R4";
            3: return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic check_vec(input logic [VW-1:0] exp_v, input string tag, input int i);
        logic [VW-1:0] act;
        act = {cke, cs_n, ras_n, cas_n, we_n, addr, ba, busy, err};
        checks++;
        if (act !== exp_v) begin
            fails++;
            $display("FAIL %s cycle %0d: actual %h expected %h", tag, i, act, exp_v);
        end
    endtask

    task automatic run_cmd(input logic [CW-1:0] w, input int intr, input logic [CW-1:0] iw);
        int op, dur;
        logic acc;
        string tag;
        op  = int'(w[2:0]);
        tag = tag_of(w, m_cke, intr);
        acc = (w[4:3] != 2'b00) && op >= 1 && op <= 4 && (op == 1 || m_cke);
        dur = 0;
        if (acc) begin
            case (op)
                1: dur = PWRUP;
                2: dur = TRP;
                3: dur = (int'(w[8:5]) + 1) * TRC;
                default: dur = TMRD;
            endcase
            if (op == 1) m_cke = 1'b1;
        end
        @(negedge clk);
        cmd_we   = 1'b1;
        cmd_word = w;
        for (int i = 0; i <= dur; i++) begin
            @(negedge clk);
            cmd_we   = (i == intr);
            cmd_word = iw;
            if (intr >= 0 && i == intr + 1) m_err = 1'b1;
            check_vec(expect_vec(w, acc, i, dur, m_cke, m_err), tag, i);
        end
        cmd_we = 1'b0;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired: actual running expected finished");
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin : stim
        logic [CW-1:0] w;
        int unsigned seed_v;
        seed_v = $urandom(32'h1d5e_ed01);
        repeat (3) @(negedge clk);
        // R1 reset state
        check_vec({1'b0, 2'b11, 3'b111, {ADDR_W{1'b0}}, 2'b00, 1'b0, 1'b0}, "R1", 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_vec({1'b0, 2'b11, 3'b111, {ADDR_W{1'b0}}, 2'b00, 1'b0, 1'b0}, "R1", 1);

        run_cmd(mk(2, 1, 1, 0, '0), -1, '0);            // R9 precharge before CKE
        run_cmd(mk(1, 0, 0, 0, '0), -1, '0);            // R2 no bank selected
        run_cmd(mk(1, 0, 1, 0, '0), -1, '0);            // R3 clock enable, CS1 only
        run_cmd(mk(2, 1, 1, 0, '0), -1, '0);            // R4 precharge, both
        run_cmd(mk(2, 1, 0, 0, '0), -1, '0);            // R4 precharge, CS0
        run_cmd(mk(3, 1, 1, 0, '0), -1, '0);            // R5 single refresh
        run_cmd(mk(3, 1, 1, 7, '0), -1, '0);            // R5 eight refreshes
        run_cmd(mk(3, 0, 1, 15, '0), -1, '0);           // R5 sixteen refreshes
        run_cmd(mk(4, 1, 1, 0, 13'h0030), -1, '0);      // R6 CL=3, BL=1
        run_cmd(mk(4, 1, 0, 0, 13'h1fff), -1, '0);      // R6 all payload bits
        run_cmd(mk(0, 1, 1, 0, '0), -1, '0);            // R7 normal
        run_cmd(mk(5, 1, 1, 3, '0), -1, '0);            // R7 self refresh
        run_cmd(mk(6, 0, 1, 3, '0), -1, '0);            // R7 power down
        run_cmd(mk(3, 1, 1, 3, '0), 4, mk(4, 1, 1, 0, 13'h0aaa)); // R8 write while busy

        for (int n = 0; n < 150; n++) begin
            w = CW'({$urandom, $urandom});
            if (w[8:5] > 4'd9) w[8:5] = 4'd2;
            run_cmd(w, ((n % 17) == 5) ? 1 : -1, CW'($urandom));
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule